// File: doc/BRIEF.md
# Two-Wire Slave Address Recognizer

This block sits on the slave side of a two-wire serial bus. It follows the bus and, after every Start condition, collects the first byte that the master sends. It then decides whether the device is being called. A call is recognised in three ways. The upper seven bits can equal a programmable own address. The whole byte can be the all-zero broadcast (general call) value, which counts only while its enable bit is set. Or a promiscuous mode can be on, in which case every byte counts as a call.

When the byte is a call, the block does four things at fixed points in the address phase. At the eighth SCL falling edge it copies the raw byte into a holding register, sets a buffer-full flag and starts pulling SDA low. At the ninth falling edge it releases SDA and pulses an interrupt. Software reads the holding register to tell its own address apart from a broadcast. It then clears the flag with a one-cycle pulse.

Top module: `i2c_addr_match`

## Requirements
- R1: SCL and SDA each pass through two synchronizing flops, which reset to the idle-high level. While reset is active, sda_pull, rx_full, match_irq and rx_byte are all 0.
- R2: A Start (SDA falls while SCL stays high) begins a new address phase and resets the bit count, even in the middle of a byte. A Stop (SDA rises while SCL stays high) abandons the phase and releases SDA.
- R3: Bits are sampled on SCL rising edges and assembled MSB first. The call decision is made only after exactly eight bits.
- R4: The byte is a call when bits [7:1] equal cfg_own_addr, whatever the R/W bit (bit 0) is.
- R5: The byte 8'h00 is a call when cfg_gc_en is 1. When cfg_gc_en is 0 it is not a call, unless R4 or R6 makes it one.
- R6: When cfg_accept_all is 1, every address byte is a call.
- R7: On a call, rx_byte takes the raw received byte and rx_full goes to 1 on the eighth SCL falling edge. When the byte is not a call, both keep their values.
- R8: On a call, sda_pull is 1 from the eighth SCL falling edge to the ninth SCL falling edge. In all other cases it stays 0.
- R9: match_irq pulses for exactly one clock at the ninth SCL falling edge of a called byte, in the same cycle that sda_pull drops.
- R10: A pulse on rx_clr clears rx_full. If a load happens in the same cycle, the load wins.
- R11: After the address phase, bus traffic has no effect until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level |
| cfg_own_addr | input | 7 | Programmable own address |
| cfg_gc_en | input | 1 | Enables broadcast (all-zero) recognition |
| cfg_accept_all | input | 1 | Treats every address as a call |
| rx_clr | input | 1 | Clears the buffer-full flag |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |
| rx_byte | output | 8 | Holding register with the last called byte |
| rx_full | output | 1 | Holding register has an unread byte |
| match_irq | output | 1 | One-cycle call interrupt |

## Verification
Some relations are checked by assertions on every cycle. The interrupt is a single-cycle pulse that always comes with SDA being released. The holding register changes only when the acknowledge pull starts. A clear with no load leaves the flag low. Other behaviours can only be shown by the bench's scenarios, which are compared against a cycle-level model: which byte values count as calls under each mode, MSB-first assembly, a Start or Stop arriving mid-byte, and the bus being ignored after the address phase.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int AW = 7,
  localparam int BW = AW + 1,
  localparam int CW = $clog2(BW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [AW-1:0] cfg_own_addr,
  input  logic          cfg_gc_en,
  input  logic          cfg_accept_all,
  input  logic          rx_clr,
  output logic          sda_pull,
  output logic [BW-1:0] rx_byte,
  output logic          rx_full,
  output logic          match_irq
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_ACK, ST_SKIP} st_t;

  logic scl_m, scl_s, scl_p;
  logic sda_m, sda_s, sda_p;
  logic [BW-1:0] shreg;
  logic [CW-1:0] bitcnt;
  st_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire full_cnt = (bitcnt == CW'(BW));

  wire own_hit = (shreg[BW-1:1] == cfg_own_addr);
  wire gc_hit  = cfg_gc_en & (shreg == '0);
  wire hit     = cfg_accept_all | own_hit | gc_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      sda_pull  <= 1'b0;
      rx_byte   <= '0;
      rx_full   <= 1'b0;
      match_irq <= 1'b0;
    end else begin
      match_irq <= 1'b0;
      if (rx_clr) rx_full <= 1'b0;
      if (start_c) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise && !full_cnt) begin
              shreg  <= {shreg[BW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && full_cnt) begin
              if (hit) begin
                rx_byte  <= shreg;
                rx_full  <= 1'b1;
                sda_pull <= 1'b1;
                st       <= ST_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_pull  <= 1'b0;
              match_irq <= 1'b1;
              st        <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_pull,
  input logic [BW-1:0] rx_byte,
  input logic          rx_full,
  input logic          match_irq,
  input logic          rx_clr
);

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> !match_irq);

  assert_irq_with_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> $fell(sda_pull));

  assert_full_rises_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $rose(sda_pull));

  assert_byte_only_on_call_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sda_pull) |-> $stable(rx_byte));

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_clr) && !$rose(sda_pull)) |-> !rx_full);

endmodule

bind i2c_addr_match i2c_addr_match_chk #(.BW(8)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .rx_byte(rx_byte),
  .rx_full(rx_full), .match_irq(match_irq), .rx_clr(rx_clr)
);

// File: tb/i2c_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_addr_match_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own = 7'h2D;
  logic gc_en = 1'b0, acc_all = 1'b0, rx_clr = 1'b0;
  logic sda_pull, rx_full, match_irq;
  logic [7:0] rx_byte;
  wire sda_line = sda_m & ~sda_pull;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .cfg_own_addr(own), .cfg_gc_en(gc_en), .cfg_accept_all(acc_all),
    .rx_clr(rx_clr), .sda_pull(sda_pull), .rx_byte(rx_byte),
    .rx_full(rx_full), .match_irq(match_irq)
  );

  // behavioural reference
  bit hs[$], hd[$];
  int m_st, m_cnt;
  logic [7:0] m_sh, m_byte;
  logic m_pull, m_full, m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      hs = '{1, 1, 1, 1}; hd = '{1, 1, 1, 1};
      m_st = 0; m_cnt = 0; m_sh = 0; m_byte = 0;
      m_pull = 0; m_full = 0; m_irq = 0;
    end else begin
      bit cs, ps, cd, pd, hit;
      hs.push_front(scl_m); hd.push_front(sda_line);
      cs = hs[2]; ps = hs[3]; cd = hd[2]; pd = hd[3];
      void'(hs.pop_back()); void'(hd.pop_back());
      m_irq = 0;
      if (rx_clr) m_full = 0;
      hit = acc_all || (m_sh[7:1] == own) || (gc_en && m_sh == 8'h00);
      if (cs && ps && pd && !cd) begin m_st = 1; m_cnt = 0; m_pull = 0; end
      else if (cs && ps && !pd && cd) begin m_st = 0; m_pull = 0; end
      else if (m_st == 1) begin
        if (cs && !ps && m_cnt < 8) begin m_sh = {m_sh[6:0], cd}; m_cnt++; end
        else if (!cs && ps && m_cnt == 8) begin
          if (hit) begin m_byte = m_sh; m_full = 1; m_pull = 1; m_st = 2; end
          else m_st = 3;
        end
      end else if (m_st == 2 && !cs && ps) begin
        m_pull = 0; m_irq = 1; m_st = 3;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(sda_pull === m_pull, "R8 sda_pull", sda_pull, m_pull);
    check(rx_byte === m_byte, "R7 rx_byte", rx_byte, m_byte);
    check(rx_full === m_full, "R7 rx_full", rx_full, m_full);
    check(match_irq === m_irq, "R9 match_irq", match_irq, m_irq);
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; wt(H); scl_m = 1; wt(H); sda_m = 0; wt(H); scl_m = 0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 0; wt(H); scl_m = 1; wt(H); sda_m = 1; wt(H);
  endtask

  task automatic bus_bit(input bit b);
    sda_m = b; wt(H); scl_m = 1; wt(H); scl_m = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    bit ack;
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    sda_m = 1; wt(H); scl_m = 1; wt(H / 2);
    ack = sda_pull;
    check(ack == exp_ack, tag, ack, exp_ack);
    wt(H / 2); scl_m = 0; wt(H);
  endtask

  task automatic pulse_clr();
    rx_clr = 1; wt(1); rx_clr = 0; wt(1);
  endtask

  initial begin
    wt(4);
    check(sda_pull == 0 && rx_full == 0 && match_irq == 0 && rx_byte == 0,
          "R1 reset outputs", {sda_pull, rx_full, match_irq}, 0);
    rst_n = 1; wt(4);

    bus_start(); send_byte(8'h5A, 1, "R4 own write ack"); bus_stop();
    check(rx_byte == 8'h5A && rx_full, "R7 held byte own write", rx_byte, 8'h5A);
    pulse_clr();
    check(!rx_full, "R10 clear", rx_full, 0);

    bus_start(); send_byte(8'h5B, 1, "R4 own read ack"); bus_stop();
    check(rx_byte == 8'h5B, "R7 held byte own read", rx_byte, 8'h5B);

    bus_start(); send_byte(8'hB4, 0, "R3 bit-order mismatch no ack"); bus_stop();
    check(rx_byte == 8'h5B, "R7 miss keeps byte", rx_byte, 8'h5B);
    pulse_clr();

    bus_start(); send_byte(8'h00, 0, "R5 broadcast disabled nack"); bus_stop();
    check(!rx_full, "R5 broadcast disabled no load", rx_full, 0);
    gc_en = 1;
    bus_start(); send_byte(8'h00, 1, "R5 broadcast enabled ack"); bus_stop();
    check(rx_byte == 8'h00 && rx_full, "R5 broadcast byte held", rx_byte, 0);
    bus_start(); send_byte(8'h01, 0, "R5 broadcast with read bit nack"); bus_stop();
    gc_en = 0; pulse_clr();

    acc_all = 1;
    bus_start(); send_byte(8'hC3, 1, "R6 accept-all ack"); bus_stop();
    check(rx_byte == 8'hC3, "R6 accept-all byte", rx_byte, 8'hC3);
    acc_all = 0; pulse_clr();

    bus_start();
    for (int i = 0; i < 4; i++) bus_bit(1'b1);
    bus_start(); send_byte(8'h5A, 1, "R2 restart mid-byte ack"); bus_stop();

    bus_start();
    for (int i = 0; i < 3; i++) bus_bit(1'b0);
    bus_stop(); scl_m = 0; wt(H);
    send_byte(8'h5A, 0, "R2 stop mid-byte no ack");
    bus_stop();

    bus_start(); send_byte(8'h5A, 1, "R11 address ack");
    send_byte(8'h5A, 0, "R11 data byte ignored"); bus_stop();

    pulse_clr();
    bus_start();
    for (int i = 7; i >= 0; i--) bus_bit(i[0] ? 1'b0 : ((8'h5A >> i) & 1) != 0);
    bus_stop();
    check(!rx_full, "R3 unrelated pattern no load", rx_full, 0);

    wt(10);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule